// File: doc/BRIEF.md
# Stack Push/Pop Decode and Hazard Control

This block sits in the decode stage of a five-stage in-order integer pipeline. It adds two custom stack instructions. `push` lowers the stack pointer by one word and stores a register at the new top of stack. `pop` reads the word at the current top into a register and then raises the stack pointer by one word. The stack pointer is architectural register x2. Neither instruction names it in its encoding, so the block adds it as a hidden source. It also adds it as a hidden destination that the ALU computes.

For the instruction in decode, the block works out which register numbers feed the two operand buses. It produces the stack-pointer adjustment for the ALU and the memory controls. It also produces the destination fields for both register-file write ports, which travel down the pipe. The destination fields of the instructions in EX, MM and WB come back in, and the block picks a bypass source for each operand. When the instruction in decode needs data that a load or a `pop` in EX is still fetching from memory, the block holds decode for one cycle and sends a bubble into EX.

Ordinary instructions pass through the same forwarding and stall logic. The main decoder supplies flags that say which of their fields are live.

Top module: `stkop_hazard_ctl`

## Requirements
- R1: `is_push` is 1 exactly when instruction bits [6:0]=1101011, [14:12]=000 and [31:25]=0000001. `is_pop` is 1 exactly when the same opcode and funct3 appear with [31:25]=0000010. No other bit pattern asserts either flag, and the two flags are never 1 together.
- R2: For `push` and `pop`, `opa_idx` is 2 (the stack pointer). For `push`, `opb_idx` is bits [24:20]. For `pop`, `opb_idx` is 0 and operand B is unused. For any other instruction, `opa_idx` is bits [19:15] when `id_rs1_used` is 1 and 0 otherwise. Likewise `opb_idx` is bits [24:20] when `id_rs2_used` is 1 and 0 otherwise.
- R3: For `push`, `sp_adj_imm` is 0xFFFFFFFC (minus 4). For `pop`, it is 0x00000004. In both cases `sp_adj_en` is 1, and for any other instruction both outputs are 0. `push` gives `mem_addr_alu`=1 and `mem_wr`=1. `pop` gives `mem_rd`=1 with `mem_addr_alu`=0, so it addresses memory with the old stack pointer.
- R4: `push` gives `dst_a_idx`=2 (an ALU result) and `dst_b_idx`=0. `pop` gives `dst_a_idx`=bits [11:7] with `dst_a_mem`=1, and `dst_b_idx`=2. Any other instruction gives `dst_a_idx`=bits [11:7] when `id_rd_wr` is 1 and 0 otherwise, with `dst_a_mem`=`id_is_load`&`id_rd_wr` and `dst_b_idx`=0.
- R5: The forwarding select codes, per used operand with a non-zero register number, are:
  - 1: the register matches an EX destination on port A that is not from memory, or on port B.
  - 2: it matches the MM port-A destination (not from memory) or the MM port-B destination.
  - 3: it matches the MM port-A destination that is from memory.
  - 4: it matches the WB port-A destination.
  - 5: it matches the WB port-B destination.
  - 0: none of the above; the register file supplies the value.
- R6: When several stages write the same register, the youngest stage wins: EX over MM over WB.
- R7: An operand whose register number is 0, or that is unused, always gets select 0.
- R8: `stall` and `ex_bubble` are both 1 exactly when a used, non-zero operand register equals `ex_dst_a` while `ex_a_mem` is 1. That operand's select is then 0. No other condition raises them.
- R9: A stack-pointer value produced by a `push` or `pop` in EX, MM or WB is forwarded without a stall, so back-to-back stack instructions never stall on x2.
- R10: `push x2` stores the old stack pointer: its operand B (register 2) is forwarded by the same rules as its operand A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the built-in property checks |
| rst_n | input | 1 | Active-low reset, gates the property checks |
| id_instr | input | 32 | Instruction word in decode |
| id_rs1_used | input | 1 | Ordinary instruction reads its rs1 field |
| id_rs2_used | input | 1 | Ordinary instruction reads its rs2 field |
| id_rd_wr | input | 1 | Ordinary instruction writes its rd field |
| id_is_load | input | 1 | Ordinary instruction takes its result from memory |
| ex_dst_a | input | 5 | EX port-A destination (0 = none) |
| ex_dst_b | input | 5 | EX port-B destination (0 = none) |
| ex_a_mem | input | 1 | EX port-A value comes from memory |
| mm_dst_a | input | 5 | MM port-A destination |
| mm_dst_b | input | 5 | MM port-B destination |
| mm_a_mem | input | 1 | MM port-A value comes from memory |
| wb_dst_a | input | 5 | WB port-A destination |
| wb_dst_b | input | 5 | WB port-B destination |
| is_push | output | 1 | Decode holds a push |
| is_pop | output | 1 | Decode holds a pop |
| opa_idx | output | 5 | Register number for operand A |
| opb_idx | output | 5 | Register number for operand B |
| fwd_a_sel | output | 3 | Bypass select for operand A |
| fwd_b_sel | output | 3 | Bypass select for operand B |
| sp_adj_en | output | 1 | ALU adds the stack step to operand A |
| sp_adj_imm | output | 32 | Signed stack step fed to the ALU |
| mem_addr_alu | output | 1 | Memory address from the ALU result (else operand A) |
| mem_wr | output | 1 | Memory store request |
| mem_rd | output | 1 | Memory load request |
| dst_a_idx | output | 5 | Port-A destination carried down the pipe |
| dst_b_idx | output | 5 | Port-B (second write port) destination, 0 when unused |
| dst_a_mem | output | 1 | Port-A value will come from memory |
| stall | output | 1 | Hold fetch and decode for one cycle |
| ex_bubble | output | 1 | Insert a bubble into EX |

## Verification
Some properties are checked on every cycle. The two stack flags never rise together, and only a pop fills the second write port. A stall always traces back to a memory-sourced destination in EX. Register 0 or an unused operand never selects a bypass. An EX destination match wins over older stages, and a pop whose stack pointer is being computed in EX never stalls. The bench's scenarios are the only place the full select codes appear. They cover the decode masks for near-miss encodings, the stack-pointer step values and the MM memory-versus-ALU split. They also show WB port-B forwarding, `push x2`, and the exact condition for the one-cycle load-use hold.

// File: rtl/stkop_pkg.sv
package stkop_pkg;

   localparam int unsigned REG_AW = 5;
   localparam int unsigned FWD_W  = 3;

   localparam logic [6:0] OPC_STACK = 7'b1101011;
   localparam logic [2:0] F3_STACK  = 3'b000;
   localparam logic [6:0] F7_PUSH   = 7'b0000001;
   localparam logic [6:0] F7_POP    = 7'b0000010;

   typedef enum logic [FWD_W-1:0] {
      FWD_RF     = 3'd0,
      FWD_EX_ALU = 3'd1,
      FWD_MM_ALU = 3'd2,
      FWD_MM_MEM = 3'd3,
      FWD_WB_A   = 3'd4,
      FWD_WB_B   = 3'd5
   } fwd_sel_e;

   typedef struct packed {
      logic [REG_AW-1:0] dst_a;
      logic [REG_AW-1:0] dst_b;
      logic              a_mem;
   } stage_dst_t;

endpackage

// File: rtl/stkop_decode.sv
module stkop_decode
   import stkop_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned SP_IDX  = 2,
   parameter int unsigned SP_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       instr,
   input  logic              rs1_used,
   input  logic              rs2_used,
   input  logic              rd_wr,
   input  logic              is_load,
   output logic              is_push,
   output logic              is_pop,
   output logic [REG_AW-1:0] opa_idx,
   output logic              opa_used,
   output logic [REG_AW-1:0] opb_idx,
   output logic              opb_used,
   output logic              sp_adj_en,
   output logic [XLEN-1:0]   sp_adj_imm,
   output logic              mem_addr_alu,
   output logic              mem_wr,
   output logic              mem_rd,
   output logic [REG_AW-1:0] dst_a_idx,
   output logic [REG_AW-1:0] dst_b_idx,
   output logic              dst_a_mem
);

   localparam logic [REG_AW-1:0] SP_R   = REG_AW'(SP_IDX);
   localparam logic [XLEN-1:0]   STEP_P = XLEN'(SP_STEP);
   localparam logic [XLEN-1:0]   STEP_N = ~STEP_P + XLEN'(1);

   generate
      if (SP_IDX < 1 || SP_IDX > 31) begin : g_bad_sp
         $error("stkop_decode: SP_IDX must name a register 1..31");
      end
      if (XLEN < 8) begin : g_bad_xlen
         $error("stkop_decode: XLEN below 8 is not supported");
      end
      if (SP_STEP == 0 || SP_STEP >= (1 << (XLEN - 2))) begin : g_bad_step
         $error("stkop_decode: SP_STEP out of range");
      end
   endgenerate

   logic [6:0]        f_opc;
   logic [2:0]        f_f3;
   logic [6:0]        f_f7;
   logic [REG_AW-1:0] f_rd, f_rs1, f_rs2;
   logic              stk_hit, any_stk;

   assign f_opc = instr[6:0];
   assign f_rd  = instr[11:7];
   assign f_f3  = instr[14:12];
   assign f_rs1 = instr[19:15];
   assign f_rs2 = instr[24:20];
   assign f_f7  = instr[31:25];

   assign stk_hit = (f_opc == OPC_STACK) && (f_f3 == F3_STACK);
   assign is_push = stk_hit && (f_f7 == F7_PUSH);
   assign is_pop  = stk_hit && (f_f7 == F7_POP);
   assign any_stk = is_push | is_pop;

   always_comb begin
      opa_used = any_stk | rs1_used;
      opa_idx  = any_stk ? SP_R : (rs1_used ? f_rs1 : '0);
      if (is_push) begin
         opb_used = 1'b1;
         opb_idx  = f_rs2;
      end else if (is_pop) begin
         opb_used = 1'b0;
         opb_idx  = '0;
      end else begin
         opb_used = rs2_used;
         opb_idx  = rs2_used ? f_rs2 : '0;
      end
   end

   always_comb begin
      sp_adj_en    = any_stk;
      sp_adj_imm   = is_push ? STEP_N : (is_pop ? STEP_P : '0);
      mem_addr_alu = is_push;
      mem_wr       = is_push;
      mem_rd       = is_pop;
   end

   always_comb begin
      if (is_push) begin
         dst_a_idx = SP_R;
         dst_b_idx = '0;
         dst_a_mem = 1'b0;
      end else if (is_pop) begin
         dst_a_idx = f_rd;
         dst_b_idx = SP_R;
         dst_a_mem = 1'b1;
      end else begin
         dst_a_idx = rd_wr ? f_rd : '0;
         dst_b_idx = '0;
         dst_a_mem = is_load & rd_wr;
      end
   end

   AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(is_push && is_pop)); // R1
   AST_W2_POP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_b_idx != '0) |-> is_pop); // R4
   AST_PUSH_MEM_CTL: assert property (@(posedge clk) disable iff (!rst_n)
      is_push |-> (mem_wr && !mem_rd && mem_addr_alu && dst_a_idx == SP_R)); // R3
   AST_POP_OLD_SP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      is_pop |-> (mem_rd && !mem_addr_alu && opa_idx == SP_R)); // R3

endmodule

// File: rtl/stkop_fwd_pick.sv
module stkop_fwd_pick
   import stkop_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] op_idx,
   input  logic              op_used,
   input  stage_dst_t        ex_d,
   input  stage_dst_t        mm_d,
   input  stage_dst_t        wb_d,
   output fwd_sel_e          sel,
   output logic              ld_hit
);

   logic live;
   assign live = op_used && (op_idx != '0);

   always_comb begin
      sel    = FWD_RF;
      ld_hit = 1'b0;
      if (live) begin
         if (op_idx == ex_d.dst_a) begin
            if (ex_d.a_mem) ld_hit = 1'b1;
            else            sel    = FWD_EX_ALU;
         end else if (op_idx == ex_d.dst_b) begin
            sel = FWD_EX_ALU;
         end else if (op_idx == mm_d.dst_a) begin
            sel = mm_d.a_mem ? FWD_MM_MEM : FWD_MM_ALU;
         end else if (op_idx == mm_d.dst_b) begin
            sel = FWD_MM_ALU;
         end else if (op_idx == wb_d.dst_a) begin
            sel = FWD_WB_A;
         end else if (op_idx == wb_d.dst_b) begin
            sel = FWD_WB_B;
         end
      end
   end

   AST_X0_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_used || op_idx == '0) |-> (sel == FWD_RF && !ld_hit)); // R7
   AST_EX_B_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_used && op_idx != '0 && op_idx == ex_d.dst_b && op_idx != ex_d.dst_a)
      |-> (sel == FWD_EX_ALU)); // R6
   AST_LD_HIT_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      ld_hit |-> (sel == FWD_RF && ex_d.a_mem)); // R8

endmodule

// File: rtl/stkop_stall_ctl.sv
module stkop_stall_ctl
   import stkop_pkg::*;
#(
   parameter int unsigned N_OPND = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_OPND-1:0] ld_hits,
   input  logic              ex_a_mem,
   input  logic [REG_AW-1:0] ex_dst_a,
   output logic              stall,
   output logic              ex_bubble
);

   generate
      if (N_OPND < 1) begin : g_bad_n
         $error("stkop_stall_ctl: N_OPND must be at least 1");
      end
   endgenerate

   assign stall     = |ld_hits;
   assign ex_bubble = |ld_hits;

   AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (ex_a_mem && ex_dst_a != '0)); // R8
   AST_NO_STALL_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_a_mem |-> (!stall && !ex_bubble)); // R8

endmodule

// File: rtl/stkop_hazard_ctl.sv
module stkop_hazard_ctl
   import stkop_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned SP_IDX  = 2,
   parameter int unsigned SP_STEP = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] id_instr,
   input  logic        id_rs1_used,
   input  logic        id_rs2_used,
   input  logic        id_rd_wr,
   input  logic        id_is_load,
   input  logic [4:0]  ex_dst_a,
   input  logic [4:0]  ex_dst_b,
   input  logic        ex_a_mem,
   input  logic [4:0]  mm_dst_a,
   input  logic [4:0]  mm_dst_b,
   input  logic        mm_a_mem,
   input  logic [4:0]  wb_dst_a,
   input  logic [4:0]  wb_dst_b,
   output logic        is_push,
   output logic        is_pop,
   output logic [4:0]  opa_idx,
   output logic [4:0]  opb_idx,
   output logic [2:0]  fwd_a_sel,
   output logic [2:0]  fwd_b_sel,
   output logic        sp_adj_en,
   output logic [XLEN-1:0] sp_adj_imm,
   output logic        mem_addr_alu,
   output logic        mem_wr,
   output logic        mem_rd,
   output logic [4:0]  dst_a_idx,
   output logic [4:0]  dst_b_idx,
   output logic        dst_a_mem,
   output logic        stall,
   output logic        ex_bubble
);

   localparam int unsigned N_OPND = 2;
   localparam logic [REG_AW-1:0] SP_R = REG_AW'(SP_IDX);

   logic              opa_used, opb_used;
   stage_dst_t        ex_d, mm_d, wb_d;
   logic [REG_AW-1:0] op_idx  [N_OPND];
   logic              op_used [N_OPND];
   fwd_sel_e          op_sel  [N_OPND];
   logic [N_OPND-1:0] op_ld_hit;

   assign ex_d = '{dst_a: ex_dst_a, dst_b: ex_dst_b, a_mem: ex_a_mem};
   assign mm_d = '{dst_a: mm_dst_a, dst_b: mm_dst_b, a_mem: mm_a_mem};
   assign wb_d = '{dst_a: wb_dst_a, dst_b: wb_dst_b, a_mem: 1'b0};

   stkop_decode #(
      .XLEN    (XLEN),
      .SP_IDX  (SP_IDX),
      .SP_STEP (SP_STEP)
   ) u_dec (
      .clk          (clk),
      .rst_n        (rst_n),
      .instr        (id_instr),
      .rs1_used     (id_rs1_used),
      .rs2_used     (id_rs2_used),
      .rd_wr        (id_rd_wr),
      .is_load      (id_is_load),
      .is_push      (is_push),
      .is_pop       (is_pop),
      .opa_idx      (opa_idx),
      .opa_used     (opa_used),
      .opb_idx      (opb_idx),
      .opb_used     (opb_used),
      .sp_adj_en    (sp_adj_en),
      .sp_adj_imm   (sp_adj_imm),
      .mem_addr_alu (mem_addr_alu),
      .mem_wr       (mem_wr),
      .mem_rd       (mem_rd),
      .dst_a_idx    (dst_a_idx),
      .dst_b_idx    (dst_b_idx),
      .dst_a_mem    (dst_a_mem)
   );

   assign op_idx[0]  = opa_idx;
   assign op_used[0] = opa_used;
   assign op_idx[1]  = opb_idx;
   assign op_used[1] = opb_used;

   generate
      for (genvar gi = 0; gi < N_OPND; gi++) begin : g_opnd
         stkop_fwd_pick u_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .op_idx  (op_idx[gi]),
            .op_used (op_used[gi]),
            .ex_d    (ex_d),
            .mm_d    (mm_d),
            .wb_d    (wb_d),
            .sel     (op_sel[gi]),
            .ld_hit  (op_ld_hit[gi])
         );
      end
   endgenerate

   assign fwd_a_sel = op_sel[0];
   assign fwd_b_sel = op_sel[1];

   stkop_stall_ctl #(
      .N_OPND (N_OPND)
   ) u_stall (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_hits   (op_ld_hit),
      .ex_a_mem  (ex_a_mem),
      .ex_dst_a  (ex_dst_a),
      .stall     (stall),
      .ex_bubble (ex_bubble)
   );

   AST_POP_SP_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pop && !(ex_a_mem && ex_dst_a == SP_R)) |-> !stall); // R9
   AST_PUSH_SP_SAME_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (is_push && opb_idx == SP_R) |-> (fwd_a_sel == fwd_b_sel)); // R10

endmodule

// File: tb/stkop_hazard_ctl_tb_top.sv
`timescale 1ns/1ps
module stkop_hazard_ctl_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [31:0] id_instr;
   logic id_rs1_used, id_rs2_used, id_rd_wr, id_is_load;
   logic [4:0] ex_dst_a, ex_dst_b, mm_dst_a, mm_dst_b, wb_dst_a, wb_dst_b;
   logic ex_a_mem, mm_a_mem;
   logic is_push, is_pop, sp_adj_en, mem_addr_alu, mem_wr, mem_rd, dst_a_mem, stall, ex_bubble;
   logic [4:0] opa_idx, opb_idx, dst_a_idx, dst_b_idx;
   logic [2:0] fwd_a_sel, fwd_b_sel;
   logic [31:0] sp_adj_imm;

   stkop_hazard_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .id_instr(id_instr),
      .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
      .id_rd_wr(id_rd_wr), .id_is_load(id_is_load),
      .ex_dst_a(ex_dst_a), .ex_dst_b(ex_dst_b), .ex_a_mem(ex_a_mem),
      .mm_dst_a(mm_dst_a), .mm_dst_b(mm_dst_b), .mm_a_mem(mm_a_mem),
      .wb_dst_a(wb_dst_a), .wb_dst_b(wb_dst_b),
      .is_push(is_push), .is_pop(is_pop), .opa_idx(opa_idx), .opb_idx(opb_idx),
      .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
      .sp_adj_en(sp_adj_en), .sp_adj_imm(sp_adj_imm),
      .mem_addr_alu(mem_addr_alu), .mem_wr(mem_wr), .mem_rd(mem_rd),
      .dst_a_idx(dst_a_idx), .dst_b_idx(dst_b_idx), .dst_a_mem(dst_a_mem),
      .stall(stall), .ex_bubble(ex_bubble)
   );

   typedef struct {
      string      tag;
      logic       push, pop;
      logic [4:0] opa, opb;
      logic       adj_en;
      logic [31:0] imm;
      logic [2:0] memc;
      logic [4:0] da, db;
      logic       dam;
      logic [2:0] fa, fb;
      logic       stl;
   } exp_t;

   exp_t exp_q[$];
   int n_cmp = 0;
   int n_bad = 0;

   logic [4:0] p_ea, p_eb, p_ma, p_mb, p_wa, p_wb;
   logic p_em, p_mm;

   function automatic logic [31:0] mk_push(input logic [4:0] r);
      return {7'b0000001, r, 5'd0, 3'b000, 5'd0, 7'b1101011};
   endfunction
   function automatic logic [31:0] mk_pop(input logic [4:0] r);
      return {7'b0000010, 5'd0, 5'd0, 3'b000, r, 7'b1101011};
   endfunction
   function automatic logic [31:0] mk_alu(input logic [4:0] rd, rs1, rs2);
      return {7'b0000000, rs2, rs1, 3'b000, rd, 7'b0110011};
   endfunction

   function automatic logic [2:0] m_fwd(input logic [4:0] r, input logic used);
      if (!used || r == 5'd0) return 3'd0;
      if (r == ex_dst_a) return ex_a_mem ? 3'd0 : 3'd1;
      if (r == ex_dst_b) return 3'd1;
      if (r == mm_dst_a) return mm_a_mem ? 3'd3 : 3'd2;
      if (r == mm_dst_b) return 3'd2;
      if (r == wb_dst_a) return 3'd4;
      if (r == wb_dst_b) return 3'd5;
      return 3'd0;
   endfunction

   task automatic set_pipe(input logic [4:0] ea, eb, input logic em,
                           input logic [4:0] ma, mb, input logic mm,
                           input logic [4:0] wa, wb);
      p_ea = ea; p_eb = eb; p_em = em;
      p_ma = ma; p_mb = mb; p_mm = mm;
      p_wa = wa; p_wb = wb;
   endtask

   task automatic drive(input logic [31:0] ins, input logic r1u, r2u, rdw, ld,
                        input string tag);
      exp_t e;
      logic ps, pp, au, bu;
      @(posedge clk);
      #1;
      id_instr = ins; id_rs1_used = r1u; id_rs2_used = r2u;
      id_rd_wr = rdw; id_is_load = ld;
      ex_dst_a = p_ea; ex_dst_b = p_eb; ex_a_mem = p_em;
      mm_dst_a = p_ma; mm_dst_b = p_mb; mm_a_mem = p_mm;
      wb_dst_a = p_wa; wb_dst_b = p_wb;
      ps = (ins[6:0] == 7'b1101011) && (ins[14:12] == 3'b000) && (ins[31:25] == 7'b0000001);
      pp = (ins[6:0] == 7'b1101011) && (ins[14:12] == 3'b000) && (ins[31:25] == 7'b0000010);
      e.tag  = tag;
      e.push = ps;
      e.pop  = pp;
      e.opa  = (ps || pp) ? 5'd2 : (r1u ? ins[19:15] : 5'd0);
      e.opb  = ps ? ins[24:20] : (pp ? 5'd0 : (r2u ? ins[24:20] : 5'd0));
      au     = ps || pp || r1u;
      bu     = ps || (!pp && r2u);
      e.adj_en = ps || pp;
      e.imm  = ps ? 32'hFFFF_FFFC : (pp ? 32'h0000_0004 : 32'h0);
      e.memc = {ps, ps, pp};
      e.da   = ps ? 5'd2 : ((pp || rdw) ? ins[11:7] : 5'd0);
      e.db   = pp ? 5'd2 : 5'd0;
      e.dam  = pp || (!ps && ld && rdw);
      e.fa   = m_fwd(e.opa, au);
      e.fb   = m_fwd(e.opb, bu);
      e.stl  = ex_a_mem && ex_dst_a != 5'd0 &&
               ((au && e.opa == ex_dst_a) || (bu && e.opb == ex_dst_a));
      exp_q.push_back(e);
   endtask

   task automatic cmp(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         cmp("R1", "is_push", 32'(is_push), 32'(e.push));
         cmp("R1", "is_pop", 32'(is_pop), 32'(e.pop));
         cmp("R2", "opa_idx", 32'(opa_idx), 32'(e.opa));
         cmp("R2", "opb_idx", 32'(opb_idx), 32'(e.opb));
         cmp("R3", "sp_adj", {sp_adj_imm[30:0], sp_adj_en}, {e.imm[30:0], e.adj_en});
         cmp("R3", "mem_ctl", 32'({mem_addr_alu, mem_wr, mem_rd}), 32'(e.memc));
         cmp("R4", "dst", 32'({dst_a_idx, dst_b_idx, dst_a_mem}), 32'({e.da, e.db, e.dam}));
         cmp(e.tag, "fwd_a_sel", 32'(fwd_a_sel), 32'(e.fa));
         cmp(e.tag, "fwd_b_sel", 32'(fwd_b_sel), 32'(e.fb));
         cmp(e.tag, "stall/bubble", 32'({stall, ex_bubble}), 32'({e.stl, e.stl}));
      end
   end

   bit done = 1'b0;
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R8 watchdog expired: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      id_instr = '0; id_rs1_used = 0; id_rs2_used = 0; id_rd_wr = 0; id_is_load = 0;
      ex_dst_a = '0; ex_dst_b = '0; ex_a_mem = 0;
      mm_dst_a = '0; mm_dst_b = '0; mm_a_mem = 0;
      wb_dst_a = '0; wb_dst_b = '0;
      set_pipe(0, 0, 0, 0, 0, 0, 0, 0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state: empty pipe, null instruction (R7, R8)
      drive(32'h0, 0, 0, 0, 0, "R7 R8 reset");

      // lui sp in EX; push t0 gets sp from EX (R5, R9)
      set_pipe(2, 0, 0, 0, 0, 0, 0, 0);
      drive(mk_push(5), 0, 0, 0, 0, "R5 R9 push sp from EX");
      // push in EX writing sp; pop t1 gets it (R9)
      set_pipe(2, 0, 0, 2, 0, 0, 0, 0);
      drive(mk_pop(6), 0, 0, 0, 0, "R9 R6 pop sp from push");
      // pop t0 in EX, push t0 in ID: load-use stall (R8)
      set_pipe(5, 2, 1, 0, 0, 0, 0, 0);
      drive(mk_push(5), 0, 0, 0, 0, "R8 R9 pop load-use");
      // after bubble: pop in MM (R5 mem/alu split)
      set_pipe(0, 0, 0, 5, 2, 1, 0, 0);
      drive(mk_push(5), 0, 0, 0, 0, "R5 MM mem and alu");
      // pop in WB: both write ports forwarded
      set_pipe(0, 0, 0, 0, 0, 0, 5, 2);
      drive(mk_push(5), 0, 0, 0, 0, "R5 WB port A and B");
      // priority among three producers of sp
      set_pipe(2, 0, 0, 2, 0, 0, 0, 2);
      drive(mk_push(7), 0, 0, 0, 0, "R6 EX over MM WB");
      set_pipe(0, 0, 0, 0, 2, 0, 2, 0);
      drive(mk_push(7), 0, 0, 0, 0, "R6 MM over WB");
      // push sp with sp produced in MM port B
      set_pipe(0, 0, 0, 9, 2, 1, 0, 0);
      drive(mk_push(2), 0, 0, 0, 0, "R10 push sp");
      set_pipe(2, 0, 0, 0, 0, 0, 0, 0);
      drive(mk_push(2), 0, 0, 0, 0, "R10 push sp EX");
      // x0 never forwarded
      set_pipe(0, 0, 0, 0, 0, 0, 0, 0);
      drive(mk_alu(1, 0, 0), 1, 1, 1, 0, "R7 x0 operands");
      drive(mk_push(0), 0, 0, 0, 0, "R7 push zero");
      // near-miss encodings decode as neither
      drive({7'b0000011, 5'd3, 5'd0, 3'b000, 5'd0, 7'b1101011}, 0, 0, 0, 0, "R1 bad funct7");
      drive({7'b0000001, 5'd3, 5'd0, 3'b001, 5'd0, 7'b1101011}, 0, 0, 0, 0, "R1 bad funct3");
      drive({7'b0000010, 5'd0, 5'd0, 3'b000, 5'd4, 7'b1101111}, 0, 0, 0, 0, "R1 bad opcode");
      // ordinary load-use
      set_pipe(6, 0, 1, 0, 0, 0, 0, 0);
      drive(mk_alu(7, 6, 1), 1, 1, 1, 0, "R8 ordinary load-use");
      drive(mk_alu(7, 1, 6), 1, 0, 1, 0, "R8 R7 unused rs2 no stall");
      // pop in EX: its sp comes from ALU, no stall for next pop
      set_pipe(8, 2, 1, 0, 0, 0, 0, 0);
      drive(mk_pop(9), 0, 0, 0, 0, "R9 pop after pop");
      // ordinary load destination fields
      set_pipe(0, 0, 0, 3, 0, 0, 0, 0);
      drive(mk_alu(3, 3, 0), 1, 0, 1, 1, "R4 R5 ordinary load");

      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule